// File: doc/BRIEF.md
# Dual-Copy Signature Self-Test Comparator

This block tells whether a purely feed-forward datapath still computes correctly at the clock and supply setting now in use. Two instances of that datapath sit beside it: a reference copy and a tested copy. The block drives one pseudo-random stimulus word to both copies every cycle of a test window. It folds each copy's response stream into its own signature register. When the window has drained, it compares the two signatures. Because both signatures are built in the same run, no golden signature has to be stored ahead of time. The method only holds when neither copy carries state from one word to the next beyond a fixed pipeline.

A test begins with a one-cycle `start` pulse and a window length. The stimulus generator is reloaded with its seed, and both signatures are cleared. The copies are assumed to answer `LAT` cycles after they see a stimulus word, so signature capture is delayed by that latency. Only responses to stimulus from inside the window are compacted. At the end of the test, `done` rises. `pass` rises with it only when the two signatures are bit-for-bit equal. Both hold until the next accepted start.

Top module: `dual_sig_check`

## Requirements
- R1: After synchronous reset, `done` and `pass` are 0 and `stim` holds the seed value.
- R2: In the cycle after an accepted start, `stim` equals the seed (default 16'hACE1).
- R3: During each of the `win_len` window cycles, `stim` advances one step of a right-shifting Galois LFSR: the next value is `stim >> 1`, XORed with the tap mask (default 16'hB400) when bit 0 is 1. Outside the window, `stim` holds its value.
- R4: Exactly `win_len` stimulus words are issued. A response is compacted only when it arrives exactly `LAT` cycles after one of those words was presented.
- R5: For a nonzero `win_len` of N, `done` becomes visible N+LAT+1 clock edges after the edge that accepted the start.
- R6: `pass` is 1 only while `done` is 1. It is 1 exactly when no response bit differed between the copies in any compacted cycle. An accepted start clears both `done` and `pass`.
- R7: A start pulse that arrives while a test is running is ignored. The running window keeps its length and its completion time.
- R8: A `win_len` of 0 issues no stimulus and raises `done` with `pass` = 1 one edge after the start.
- R9: A difference between the two response buses in a cycle that is not compacted (before the first delayed response, or after the last one) does not affect `pass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle test request, accepted only when idle or done |
| win_len | input | CNT_W | Number of stimulus cycles in the window |
| stim | output | STIM_W | Stimulus word driven to both copies |
| ref_resp | input | RESP_W | Response of the reference copy |
| dut_resp | input | RESP_W | Response of the tested copy |
| done | output | 1 | Test finished; held until the next accepted start |
| pass | output | 1 | Signatures matched; valid with done |

## Verification
The hardest situation to reach is a divergence that lands exactly on the boundary of the compaction window. A fault one cycle before the first delayed response, or one cycle after the last one, must be ignored. A fault inside that span must fail the test. The bench places a one-cycle error mask on the tested copy's response at cycle offsets computed from the window length and the copy latency. It checks that the outcome flips at precisely those offsets. It also fires a second start in the middle of a window, to show that the running test is neither restarted nor shortened.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } phase_e;

    typedef struct packed {
        logic load;   // reseed stimulus generator
        logic step;   // advance stimulus generator
        logic clr;    // clear both signatures
        logic cap;    // fold current responses into signatures
    } seq_ctl_t;

    function automatic logic phase_busy(phase_e p);
        return (p == ST_RUN) || (p == ST_DRAIN);
    endfunction

endpackage

// File: rtl/st_lfsr.sv
module st_lfsr #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   TAPS = 16'hB400,
    parameter logic [W-1:0]   SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] state
);

    logic [W-1:0] nxt;

    always_comb begin
        nxt = state >> 1;
        if (state[0]) nxt = nxt ^ TAPS;
    end

    always_ff @(posedge clk) begin
        if (rst)       state <= SEED;
        else if (load) state <= SEED;
        else if (step) state <= nxt;
    end

    p_seed_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> state == SEED);

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(state));

    p_never_zero_r3: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/st_misr.sv
module st_misr #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         cap,
    input  logic [W-1:0] resp,
    output logic [W-1:0] sig
);

    logic [W-1:0] folded;

    always_comb begin
        folded = {sig[W-2:0], 1'b0} ^ resp;
        if (sig[W-1]) folded = folded ^ POLY;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) sig <= '0;
        else if (cap)   sig <= folded;
    end

    p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
        clr |=> sig == '0);

    p_hold_no_cap_r4: assert property (@(posedge clk) disable iff (rst)
        (!clr && !cap) |=> $stable(sig));

endmodule

// File: rtl/st_window.sv
module st_window
    import selftest_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LAT   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] win_len,
    input  logic             sig_match,
    output seq_ctl_t         ctl,
    output logic             done,
    output logic             pass
);

    phase_e           phase;
    logic [CNT_W-1:0] remain;
    logic [LAT-1:0]   vpipe;
    logic             accept;
    logic             active;

    assign accept = start && !phase_busy(phase);
    assign active = (phase == ST_RUN);

    always_comb begin
        ctl.load = accept;
        ctl.clr  = accept;
        ctl.step = active;
        ctl.cap  = vpipe[LAT-1];
    end

    generate
        if (LAT == 1) begin : g_vp1
            always_ff @(posedge clk) begin
                if (rst) vpipe <= '0;
                else     vpipe <= active;
            end
        end else begin : g_vpn
            always_ff @(posedge clk) begin
                if (rst) vpipe <= '0;
                else     vpipe <= {vpipe[LAT-2:0], active};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= ST_IDLE;
            remain <= '0;
            pass   <= 1'b0;
        end else if (accept) begin
            remain <= win_len;
            pass   <= 1'b0;
            phase  <= (win_len == '0) ? ST_DRAIN : ST_RUN;
        end else begin
            case (phase)
                ST_RUN: begin
                    remain <= remain - 1'b1;
                    if (remain == {{(CNT_W-1){1'b0}}, 1'b1}) phase <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (vpipe == '0) begin
                        phase <= ST_DONE;
                        pass  <= sig_match;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done = (phase == ST_DONE);

    p_pass_needs_done_r6: assert property (@(posedge clk) disable iff (rst)
        pass |-> done);

    p_start_clears_r6: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!done && !pass));

    p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (active && start) |=> remain == $past(remain) - 1'b1);

    p_cap_inside_test_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.cap |-> phase_busy(phase));

    p_done_held_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(pass)));

endmodule

// File: rtl/dual_sig_check.sv
module dual_sig_check
    import selftest_pkg::*;
#(
    parameter int                STIM_W    = 16,
    parameter int                RESP_W    = 16,
    parameter int                CNT_W     = 16,
    parameter int                LAT       = 3,
    parameter logic [STIM_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [STIM_W-1:0] LFSR_SEED = 16'hACE1,
    parameter logic [RESP_W-1:0] MISR_POLY = 16'h1021
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  win_len,
    output logic [STIM_W-1:0] stim,
    input  logic [RESP_W-1:0] ref_resp,
    input  logic [RESP_W-1:0] dut_resp,
    output logic              done,
    output logic              pass
);

    localparam int NCOPY = 2;

    seq_ctl_t          ctl;
    logic [RESP_W-1:0] resp_arr [NCOPY];
    logic [RESP_W-1:0] sig_arr  [NCOPY];
    logic              sig_match;

    assign resp_arr[0] = ref_resp;
    assign resp_arr[1] = dut_resp;
    assign sig_match   = (sig_arr[0] == sig_arr[1]);

    st_window #(.CNT_W(CNT_W), .LAT(LAT)) u_win (
        .clk(clk), .rst(rst), .start(start), .win_len(win_len),
        .sig_match(sig_match), .ctl(ctl), .done(done), .pass(pass)
    );

    st_lfsr #(.W(STIM_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_gen (
        .clk(clk), .rst(rst), .load(ctl.load), .step(ctl.step), .state(stim)
    );

    generate
        for (genvar g = 0; g < NCOPY; g++) begin : g_sig
            st_misr #(.W(RESP_W), .POLY(MISR_POLY)) u_misr (
                .clk(clk), .rst(rst), .clr(ctl.clr), .cap(ctl.cap),
                .resp(resp_arr[g]), .sig(sig_arr[g])
            );
        end
    endgenerate

endmodule

// File: tb/dual_sig_check_test.sv
`timescale 1ns/1ps
module dual_sig_check_test;

    localparam int          W    = 16;
    localparam int          LAT  = 3;
    localparam logic [15:0] TAPS = 16'hB400;
    localparam logic [15:0] SEED = 16'hACE1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] win_len = '0;
    logic [15:0] stim;
    logic [15:0] ref_resp, dut_resp;
    logic [15:0] fault = '0;
    logic        done, pass;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    dual_sig_check uut (
        .clk(clk), .rst(rst), .start(start), .win_len(win_len),
        .stim(stim), .ref_resp(ref_resp), .dut_resp(dut_resp),
        .done(done), .pass(pass)
    );

    // two identical feed-forward copies with LAT register stages
    logic [15:0] pipe [LAT];
    always @(posedge clk) begin
        pipe[0] <= {stim[7:0], stim[15:8]} ^ 16'h5A5A;
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
    assign ref_resp = pipe[LAT-1];
    assign dut_resp = pipe[LAT-1] ^ fault;

    // behavioural reference model
    logic [15:0] m_lfsr;
    int          m_rem;
    bit          m_busy, m_done, m_pass, m_err;
    bit          m_q [$];

    always @(posedge clk) begin
        if (rst) begin
            m_lfsr = SEED; m_rem = 0; m_busy = 0; m_done = 0; m_pass = 0; m_err = 0;
            m_q = {};
            for (int i = 0; i < LAT; i++) m_q.push_back(1'b0);
        end else begin
            bit was_busy, act, vnow, any;
            was_busy = m_busy;
            act  = (m_rem != 0);
            vnow = m_q[0];
            any  = 0;
            foreach (m_q[i]) if (m_q[i]) any = 1;
            if (vnow && fault != 0) m_err = 1;
            if (was_busy && !act && !any) begin
                m_busy = 0; m_done = 1; m_pass = !m_err;
            end
            void'(m_q.pop_front());
            m_q.push_back(act);
            if (act) begin
                m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? TAPS : 16'h0);
                m_rem--;
            end
            if (start && !was_busy) begin
                m_busy = 1; m_rem = win_len; m_lfsr = SEED;
                m_done = 0; m_pass = 0; m_err = 0;
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(stim == m_lfsr, "R3 stim", stim, m_lfsr);
            check(done == m_done, "R5 done", done, m_done);
            check(pass == m_pass, "R6 pass", pass, m_pass);
        end
    end

    // n: window, fd: fault cycle offset (-1 none), rd: restart offset (-1 none)
    task automatic run(int n, int fd, int rd, bit exp_pass, string tag);
        int seen = -1;
        @(negedge clk);
        start = 1; win_len = n[15:0];
        for (int c = 1; c < n + LAT + 40; c++) begin
            @(negedge clk);
            if (c == 1) check(stim == SEED, "R2 seed", stim, SEED);
            if (done && seen < 0) seen = c - 1;
            start   = (c == rd);
            win_len = (c == rd) ? 16'd5 : n[15:0];
            fault   = (c - 1 == fd) ? 16'h0100 : 16'h0;
            if (seen >= 0 && c > seen + 2) break;
        end
        start = 0; fault = 0;
        check(seen == ((n == 0) ? 1 : n + LAT + 1), {tag, " latency"}, seen,
              (n == 0) ? 1 : n + LAT + 1);
        check(pass == exp_pass, {tag, " result"}, pass, exp_pass);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(done == 0 && pass == 0, "R1 reset flags", {done, pass}, 0);
        check(stim == SEED, "R1 reset stim", stim, SEED);

        run(20, -1, -1, 1, "R4 clean window");
        run(20, LAT + 5, -1, 0, "R6 mid fault");
        run(20, LAT, -1, 0, "R4 first compacted fault");
        run(20, 20 + LAT - 1, -1, 0, "R4 last compacted fault");
        run(20, LAT - 1, -1, 1, "R9 early fault ignored");
        run(20, 20 + LAT, -1, 1, "R9 late fault ignored");
        run(30, -1, 8, 1, "R7 busy start ignored");
        run(0, -1, -1, 1, "R8 zero window");
        run(1, -1, -1, 1, "R5 single word");
        run(1, LAT, -1, 0, "R6 single word fault");
        run(300, 250, -1, 0, "R5 long window");
        run(300, -1, -1, 1, "R5 long clean");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule